// File: doc/BRIEF.md
# Nine/three-level sample quantizer

This block reduces a stream of signed 8-bit samples to ternary digits for a bank of four correlators. The correlators take the two output lanes and form all four pairwise products (A×A, B×B, A×B, B×A). The lanes mean different things in the two operating modes.

In nine-level mode, every valid sample is graded into a level between −4 and +4. The level is written in balanced ternary as one high-order digit and one low-order digit. The high digit goes out on lane A and the low digit on lane B, one register stage after the sample arrives.

In three-level mode, which doubles the bandwidth, every sample becomes a single ternary digit. Consecutive samples are grouped into odd/even pairs. The odd sample goes out on lane A and the even sample on lane B, with one valid pulse per pair. The mode select is honoured only between pairs, so a half-built pair is never split.

Top module: `coarse_quant`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and both lanes are 2'b00.
- R2: Each lane carries a ternary digit coded as 2'b00 = 0, 2'b01 = +1, 2'b11 = −1; the code 2'b10 never appears while `out_valid` is 1.
- R3: In nine-level mode, the level's magnitude is the number of entries of `thr9` that are less than or equal to |x|. Its sign is the sign of x. The four thresholds must be strictly ascending with `thr9[0]` smallest.
- R4: In nine-level mode, the level v is split as v = 3·H + L with H, L in {−1, 0, +1}; H is placed on `lane_a` and L on `lane_b`.
- R5: In nine-level mode, every accepted sample gives an `out_valid` pulse with its digits in the cycle after the clock edge that accepts it.
- R6: In three-level mode, a sample becomes +1 if x ≥ `thr3`, −1 if x ≤ −`thr3`, and 0 otherwise.
- R7: In three-level mode, the first sample after reset or after a completed pair is the odd sample and produces no output. The next accepted sample is the even one. One cycle after the even sample, `out_valid` pulses with the odd digit on `lane_a` and the even digit on `lane_b`.
- R8: While an odd sample is waiting for its partner, `nine_lvl` is ignored. The next accepted sample is quantized as the three-level even sample. The mode select takes effect again only once that pair is complete.
- R9: A cycle with `in_valid` low gives no `out_valid` pulse, leaves both lanes unchanged and keeps any waiting odd sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample on `in_sample` is accepted this cycle |
| in_sample | input | 8 | Signed two's-complement sample |
| nine_lvl | input | 1 | 1 = nine-level mode, 0 = three-level pair mode |
| thr9 | input | 4×8 | Ascending unsigned magnitude thresholds for nine-level grading |
| thr3 | input | 8 | Unsigned magnitude threshold for three-level mode |
| out_valid | output | 1 | Lanes carry a new digit pair this cycle |
| lane_a | output | 2 | High digit (nine-level) or odd-sample digit (three-level) |
| lane_b | output | 2 | Low digit (nine-level) or even-sample digit (three-level) |

## Verification
The one piece of hidden state is the flag for a waiting odd sample. If it is wrong, the damage shows at the ports within one accepted sample. Either a pulse appears after a lone odd sample, or a pulse is missing after the even one, or a nine-level sample is taken as an even partner. After that, every later pair in the stream is shifted by one.

A wrong grading threshold or a wrong digit split shows up in the very next output pulse as a wrong digit on one lane. So the stimulus walks each threshold edge from both sides and for both signs, including the most negative sample. It also switches the mode select while a pair is half built.

// File: rtl/cq_pkg.sv
// Shared types for the coarse quantizer: ternary digit codes and the
// number of grading thresholds used in nine-level mode.
package cq_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_POS  = 2'b01;
    localparam trit_t TRIT_NEG  = 2'b11;

    // Nine levels need four magnitude edges (grades 0..4).
    localparam int NINE_THR = 4;

    // Arithmetic negation of one coded ternary digit.
    function automatic trit_t trit_negate(input trit_t t);
        case (t)
            TRIT_POS: return TRIT_NEG;
            TRIT_NEG: return TRIT_POS;
            default:  return TRIT_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/cq_grader.sv
// Magnitude grader.
// Takes the absolute value of a signed sample and counts how many of NTHR
// thresholds it reaches or exceeds. Returns that count and the sign.
// Assumes the thresholds ascend, so the hit vector is a thermometer code.
// The most negative input maps to magnitude 2^(SW-1), which still fits in SW bits.
module cq_grader #(
    parameter int SW   = 8,
    parameter int NTHR = 4,
    localparam int GW  = $clog2(NTHR + 1)
) (
    input  logic signed [SW-1:0]           smp,
    input  logic [NTHR-1:0][SW-1:0]        thr,
    output logic                           neg,
    output logic [GW-1:0]                  grade
);

    logic [SW-1:0]   mag;
    logic [NTHR-1:0] hit;

    // Absolute value in unsigned form.
    always_comb begin
        neg = smp[SW-1];
        mag = neg ? (~smp + 1'b1) : smp;
    end

    // One comparator per threshold.
    for (genvar k = 0; k < NTHR; k++) begin : g_cmp
        assign hit[k] = (mag >= thr[k]);
    end

    // Grade is the population of the thermometer vector.
    always_comb begin
        grade = GW'($countones(hit));
    end

endmodule

// File: rtl/cq_btern.sv
// Balanced-ternary splitter for nine-level mode.
// Maps a sign and a grade 0..4 to a high and a low digit with level = 3*H + L.
// Assumes the grade never exceeds 4; anything larger is forced to zero.
module cq_btern
    import cq_pkg::*;
#(
    parameter int GW = 3
) (
    input  logic          neg,
    input  logic [GW-1:0] grade,
    output trit_t         hi,
    output trit_t         lo
);

    trit_t hi_pos;
    trit_t lo_pos;

    // Digits of the non-negative magnitude.
    always_comb begin
        case (grade)
            GW'(1):  begin hi_pos = TRIT_ZERO; lo_pos = TRIT_POS;  end
            GW'(2):  begin hi_pos = TRIT_POS;  lo_pos = TRIT_NEG;  end
            GW'(3):  begin hi_pos = TRIT_POS;  lo_pos = TRIT_ZERO; end
            GW'(4):  begin hi_pos = TRIT_POS;  lo_pos = TRIT_POS;  end
            default: begin hi_pos = TRIT_ZERO; lo_pos = TRIT_ZERO; end
        endcase
    end

    // Mirror both digits for negative samples.
    always_comb begin
        hi = neg ? trit_negate(hi_pos) : hi_pos;
        lo = neg ? trit_negate(lo_pos) : lo_pos;
    end

endmodule

// File: rtl/coarse_quant.sv
// Nine/three-level quantizer top.
// In nine-level mode each sample becomes a high/low balanced-ternary digit pair.
// In three-level mode samples are paired as odd/even onto the same two lanes.
// One register stage sits between the sample and the lanes.
// The mode select is sampled only when no odd sample is waiting.
// Assumes thr9 is strictly ascending; an assertion guards this.
module coarse_quant
    import cq_pkg::*;
#(
    parameter int SW = 8,
    localparam int GW9 = $clog2(NINE_THR + 1),
    localparam int GW3 = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic signed [SW-1:0]          in_sample,
    input  logic                          nine_lvl,
    input  logic [NINE_THR-1:0][SW-1:0]   thr9,
    input  logic [SW-1:0]                 thr3,
    output logic                          out_valid,
    output logic [1:0]                    lane_a,
    output logic [1:0]                    lane_b
);

    logic           neg9, neg3;
    logic [GW9-1:0] grade9;
    logic [GW3-1:0] grade3;
    trit_t          hi9, lo9, t3;
    trit_t          odd_q;
    logic           pend_q;
    logic           take_nine;

    cq_grader #(.SW(SW), .NTHR(NINE_THR)) u_grade9 (
        .smp(in_sample), .thr(thr9), .neg(neg9), .grade(grade9)
    );

    cq_grader #(.SW(SW), .NTHR(1)) u_grade3 (
        .smp(in_sample), .thr(thr3), .neg(neg3), .grade(grade3)
    );

    cq_btern #(.GW(GW9)) u_split (
        .neg(neg9), .grade(grade9), .hi(hi9), .lo(lo9)
    );

    // Single three-level digit from the one-threshold grade.
    always_comb begin
        if (grade3 != '0) t3 = neg3 ? TRIT_NEG : TRIT_POS;
        else              t3 = TRIT_ZERO;
    end

    // Nine-level handling only at a pair boundary.
    assign take_nine = nine_lvl && !pend_q;

    // Odd-sample holding register and pair phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            odd_q  <= TRIT_ZERO;
        end else if (in_valid && !take_nine) begin
            pend_q <= !pend_q;
            if (!pend_q) odd_q <= t3;
        end
    end

    // Output pipeline stage: lanes and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            lane_a    <= TRIT_ZERO;
            lane_b    <= TRIT_ZERO;
        end else begin
            out_valid <= 1'b0;
            if (in_valid && take_nine) begin
                out_valid <= 1'b1;
                lane_a    <= hi9;
                lane_b    <= lo9;
            end else if (in_valid && pend_q) begin
                out_valid <= 1'b1;
                lane_a    <= odd_q;
                lane_b    <= t3;
            end
        end
    end

    // Threshold ordering test used by the guard below.
    function automatic logic thr_rising(input logic [NINE_THR-1:0][SW-1:0] t);
        logic ok;
        ok = 1'b1;
        for (int i = 1; i < NINE_THR; i++) begin
            if (t[i] <= t[i-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R3
    thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && take_nine) |-> thr_rising(thr9));

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lane_a != 2'b10 && lane_b != 2'b10));

    // R5
    nine_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nine_lvl && !pend_q) |=> out_valid);

    // R7
    odd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !nine_lvl && !pend_q) |=> (!out_valid && pend_q));

    // R8
    even_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pend_q) |=> (out_valid && !pend_q && lane_a == $past(odd_q)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(lane_a) && $stable(lane_b) && $stable(pend_q)));

endmodule

// File: tb/coarse_quant_tb.sv
`timescale 1ns/1ps
module coarse_quant_tb_top;

    localparam int SW = 8;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  in_valid;
    logic signed [SW-1:0]  in_sample;
    logic                  nine_lvl;
    logic [3:0][SW-1:0]    thr9;
    logic [SW-1:0]         thr3;
    logic                  out_valid;
    logic [1:0]            lane_a;
    logic [1:0]            lane_b;

    always #2.5 clk = ~clk;

    coarse_quant #(.SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .nine_lvl(nine_lvl), .thr9(thr9), .thr3(thr3),
        .out_valid(out_valid), .lane_a(lane_a), .lane_b(lane_b)
    );

    typedef struct {
        int         due;
        logic [1:0] a;
        logic [1:0] b;
        string      req;
    } exp_t;

    exp_t       sb[$];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         mon_on = 0;
    bit         done = 0;
    logic [1:0] last_a = 2'b00;
    logic [1:0] last_b = 2'b00;

    // Bench-side pairing model.
    bit         pend = 0;
    logic [1:0] odd_code = 2'b00;

    int T9 [4] = '{10, 30, 60, 100};
    int T3 = 20;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] code(input int t);
        if (t > 0) return 2'b01;
        if (t < 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic int level9(input int x);
        int m, g;
        m = (x < 0) ? -x : x;
        g = 0;
        for (int i = 0; i < 4; i++) if (m >= T9[i]) g++;
        return (x < 0) ? -g : g;
    endfunction

    function automatic int tern3(input int x);
        if (x >= T3) return 1;
        if (x <= -T3) return -1;
        return 0;
    endfunction

    task automatic push(input logic [1:0] a, input logic [1:0] b, input string req);
        exp_t e;
        e.due = cyc + 1; e.a = a; e.b = b; e.req = req;
        sb.push_back(e);
    endtask

    // Driver: presents one sample and records what it should produce.
    task automatic drive(input int x, input bit nine, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SW'(x);
        nine_lvl  = nine;
        if (!pend && nine) begin
            int v, h;
            v = level9(x);
            h = (v >= 2) ? 1 : ((v <= -2) ? -1 : 0);
            push(code(h), code(v - 3 * h), req);
        end else if (!pend) begin
            pend = 1;
            odd_code = code(tern3(x));
        end else begin
            push(odd_code, code(tern3(x)), req);
            pend = 0;
        end
    endtask

    task automatic idle(input int n, input bit nine);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 8'sh55;
            nine_lvl  = nine;
        end
    endtask

    // Monitor: compares scheduled results and idle behaviour.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_valid !== 1'b1 || lane_a !== e.a || lane_b !== e.b) begin
                    errors++;
                    $display("FAIL %s: actual v=%b a=%b b=%b expected v=1 a=%b b=%b",
                             e.req, out_valid, lane_a, lane_b, e.a, e.b);
                end
                last_a = e.a;
                last_b = e.b;
            end else begin
                checks++;
                if (out_valid !== 1'b0 || lane_a !== last_a || lane_b !== last_b) begin
                    errors++;
                    $display("FAIL R9/R7 quiet cycle: actual v=%b a=%b b=%b expected v=0 a=%b b=%b",
                             out_valid, lane_a, lane_b, last_a, last_b);
                end
            end
        end
    end

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_sample = 8'sh7f; nine_lvl = 1'b1;
        for (int i = 0; i < 4; i++) thr9[i] = SW'(T9[i]);
        thr3 = SW'(T3);
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset even with valid input.
        checks++;
        if (out_valid !== 1'b0 || lane_a !== 2'b00 || lane_b !== 2'b00) begin
            errors++;
            $display("FAIL R1 reset: actual v=%b a=%b b=%b expected v=0 a=00 b=00",
                     out_valid, lane_a, lane_b);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1;

        // R3 R4 R5: nine-level grading across every edge, back to back.
        foreach (T9[i]) begin
            drive(T9[i] - 1, 1, "R3 below edge");
            drive(T9[i],     1, "R4 at edge");
            drive(-T9[i],    1, "R4 neg edge");
            drive(1 - T9[i], 1, "R3 neg below");
        end
        drive(0,    1, "R3 zero");
        drive(127,  1, "R5 max");
        drive(-128, 1, "R3 most negative");
        idle(2, 1);

        // R6 R7: three-level pairs.
        drive(25,  0, "R7 odd");
        drive(-25, 0, "R6 pair +/-");
        drive(19,  0, "R7 odd");
        drive(-20, 0, "R6 pair 0/-");
        drive(-19, 0, "R7 odd");
        drive(20,  0, "R6 pair 0/+");
        drive(-128, 0, "R7 odd");
        drive(127,  0, "R6 pair extremes");

        // R9: gap between odd and even.
        drive(40, 0, "R9 odd");
        idle(3, 0);
        drive(-5, 0, "R9 held odd");
        idle(1, 0);

        // R8: mode raised while an odd sample waits.
        drive(-60, 0, "R8 odd");
        drive(100, 1, "R8 even despite nine");
        drive(100, 1, "R8 nine after pair");
        drive(-35, 1, "R8 nine after pair");
        drive(33,  0, "R8 odd");
        idle(2, 1);
        drive(-70, 1, "R8 even after idle");
        drive(-70, 1, "R5 nine resumes");
        idle(4, 1);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5 leftover: actual=%0d expected=0", sb.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule